// File: doc/BRIEF.md
# Phase to Sine/Cosine Generator

This block turns a stream of phase words into a stream of complex unit phasors. These are the cosine/sine pairs that a mixer multiplies into a sample stream to shift it in frequency. Each phase word is an unsigned fraction of a full turn. The block answers it with the cosine and the sine of that angle, packed into one word. The packet-end flag of the phase word travels with its answer.

The angle is resolved from the top bits of the phase. Two bits pick the quadrant, and the next bits index a quarter-wave sine table that is computed when the design is elaborated. Cosine and sine are read from mirrored positions of that table, and then a quadrant fold swaps and negates them.

The three pipeline stages move together, and only when the block accepts a new phase word. A stream is therefore pushed out by feeding extra phase words after it. Output back-pressure stalls the input, and the output word holds still while it waits.

Top module: `phasor_gen`

## Requirements
- R1: For a phase word p (24 bits, a full turn is 2^24), the output equals round(16384·cos θ) and round(16384·sin θ) to within 1 LSB, where θ = 2π·p[23:16]/256. Bits [23:22] select the quadrant and bits [21:16] index the quarter table.
- R2: The output word is 32 bits. Sine is in bits [31:16] and cosine is in bits [15:0]. Each is a two's-complement Q2.14 value whose magnitude never exceeds 16384. Phase 0x400000 gives exactly 0x40000000.
- R3: The four cardinal angles are exact. 0x000000 gives (cos, sin) = (16384, 0). 0x400000 gives (0, 16384). 0x800000 gives (−16384, 0). 0xC00000 gives (0, −16384).
- R4: Phase bits [15:0] have no effect on the output. For example, 0x00FFFF gives the same result as 0x000000.
- R5: The last flag presented with a phase word appears on the output together with that word's result.
- R6: With input valid held every cycle and output ready high, the result of a phase word accepted in cycle t is presented as valid in cycle t+3.
- R7: The pipeline advances only on an accepted input transfer. Output valid rises only after such a transfer. After input stops, the two most recent words stay inside and produce no output.
- R8: While output valid is high and output ready is low, input ready is low, and output data and last stay unchanged.
- R9: Reset is active low and synchronous. While it is low, output valid and input ready are low. Input ready also stays low for one further cycle after release, so the effective reset always covers at least two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_phase_valid | input | 1 | Phase word valid |
| s_phase_ready | output | 1 | Phase word accepted when high together with valid |
| s_phase_data | input | 24 | Phase word, unsigned fraction of a full turn |
| s_phase_last | input | 1 | Packet-end flag of the phase word |
| m_iq_valid | output | 1 | Phasor word valid |
| m_iq_ready | input | 1 | Downstream accepts the phasor word |
| m_iq_data | output | 32 | {sine, cosine}, each signed Q2.14 |
| m_iq_last | output | 1 | Packet-end flag of the phasor word |

## Verification
A wrong quadrant code or a swapped table read shows up as a sign or axis error. It appears on the output of the third accepted transfer after the faulty word, and the four cardinal phases expose it exactly. A lost or stuck stage-valid bit shows up as a missing, duplicated or out-of-order sample, or as a flag that lands on the wrong sample. These errors appear within three accepted transfers. A fault in the stall or flush logic shows up at once: data changes under back-pressure, or an output appears after input has stopped.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

    localparam int PHASE_W = 24;   // phase word width
    localparam int IDX_W   = 6;    // quarter-table index bits
    localparam int OUT_W   = 16;   // component width
    localparam int FRAC_W  = 14;   // fractional bits of a component

    // Quarter-wave entry i of 2**idx_w + 1 points, scaled to 2**frac_w.
    function automatic int quarter_sine(input int i, input int idx_w, input int frac_w);
        real ang;
        real v;
        ang = 3.14159265358979323846 / 2.0 * real'(i) / real'(1 << idx_w);
        v   = real'(1 << frac_w) * $sin(ang);
        return $rtoi(v + 0.5);
    endfunction

endpackage

// File: rtl/sincos_qtable.sv
module sincos_qtable #(
    parameter int IDX_W  = sincos_pkg::IDX_W,
    parameter int OUT_W  = sincos_pkg::OUT_W,
    parameter int FRAC_W = sincos_pkg::FRAC_W
) (
    input  logic [IDX_W-1:0]        idx,
    output logic signed [OUT_W-1:0] near_val,  // sin of the index angle
    output logic signed [OUT_W-1:0] far_val    // sin of the mirrored angle
);
    localparam int N = 1 << IDX_W;

    logic signed [OUT_W-1:0] rom [0:N];
    logic [IDX_W:0]          mirror_idx;

    for (genvar i = 0; i <= N; i++) begin : g_rom
        assign rom[i] = OUT_W'(sincos_pkg::quarter_sine(i, IDX_W, FRAC_W));
    end

    assign mirror_idx = (IDX_W+1)'(N) - {1'b0, idx};
    assign near_val   = rom[{1'b0, idx}];
    assign far_val    = rom[mirror_idx];

endmodule

// File: rtl/sincos_fold.sv
module sincos_fold #(
    parameter int OUT_W = sincos_pkg::OUT_W
) (
    input  logic [1:0]              quad,
    input  logic signed [OUT_W-1:0] near_val,
    input  logic signed [OUT_W-1:0] far_val,
    output logic signed [OUT_W-1:0] cos_o,
    output logic signed [OUT_W-1:0] sin_o
);
    always_comb begin
        case (quad)
            2'd0: begin cos_o = far_val;   sin_o = near_val;  end
            2'd1: begin cos_o = -near_val; sin_o = far_val;   end
            2'd2: begin cos_o = -far_val;  sin_o = -near_val; end
            default: begin cos_o = near_val; sin_o = -far_val; end
        endcase
    end

endmodule

// File: rtl/phasor_gen.sv
module phasor_gen #(
    parameter int PHASE_W = sincos_pkg::PHASE_W,
    parameter int IDX_W   = sincos_pkg::IDX_W,
    parameter int OUT_W   = sincos_pkg::OUT_W,
    parameter int FRAC_W  = sincos_pkg::FRAC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_phase_valid,
    output logic                 s_phase_ready,
    input  logic [PHASE_W-1:0]   s_phase_data,
    input  logic                 s_phase_last,
    output logic                 m_iq_valid,
    input  logic                 m_iq_ready,
    output logic [2*OUT_W-1:0]   m_iq_data,
    output logic                 m_iq_last
);
    localparam int SEL_W = 2 + IDX_W;
    localparam int LSB_W = PHASE_W - SEL_W;

    typedef struct packed {
        logic                    a_v;
        logic [1:0]              a_quad;
        logic [IDX_W-1:0]        a_idx;
        logic                    a_last;
        logic                    b_v;
        logic [1:0]              b_quad;
        logic signed [OUT_W-1:0] b_near;
        logic signed [OUT_W-1:0] b_far;
        logic                    b_last;
        logic                    c_v;
        logic signed [OUT_W-1:0] c_cos;
        logic signed [OUT_W-1:0] c_sin;
        logic                    c_last;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    logic  rst_seen_q;
    logic  rst_int;
    logic  accept;

    logic signed [OUT_W-1:0] tab_near, tab_far;
    logic signed [OUT_W-1:0] fold_cos, fold_sin;
    logic                    unused_low;

    assign unused_low = ^s_phase_data[LSB_W-1:0];

    sincos_qtable #(.IDX_W(IDX_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_table (
        .idx      (pipe_q.a_idx),
        .near_val (tab_near),
        .far_val  (tab_far)
    );

    sincos_fold #(.OUT_W(OUT_W)) u_fold (
        .quad     (pipe_q.b_quad),
        .near_val (pipe_q.b_near),
        .far_val  (pipe_q.b_far),
        .cos_o    (fold_cos),
        .sin_o    (fold_sin)
    );

    // Reset is stretched by one edge so that it always spans two edges.
    assign rst_int       = !rst_n || !rst_seen_q;
    assign s_phase_ready = !rst_int && !(pipe_q.c_v && !m_iq_ready);
    assign accept        = s_phase_valid && s_phase_ready;

    always_comb begin
        pipe_d = pipe_q;
        if (pipe_q.c_v && m_iq_ready) begin
            pipe_d.c_v = 1'b0;
        end
        if (accept) begin
            pipe_d.a_v    = 1'b1;
            pipe_d.a_quad = s_phase_data[PHASE_W-1 -: 2];
            pipe_d.a_idx  = s_phase_data[PHASE_W-3 -: IDX_W];
            pipe_d.a_last = s_phase_last;
            pipe_d.b_v    = pipe_q.a_v;
            pipe_d.b_quad = pipe_q.a_quad;
            pipe_d.b_near = tab_near;
            pipe_d.b_far  = tab_far;
            pipe_d.b_last = pipe_q.a_last;
            pipe_d.c_v    = pipe_q.b_v;
            pipe_d.c_cos  = fold_cos;
            pipe_d.c_sin  = fold_sin;
            pipe_d.c_last = pipe_q.b_last;
        end
    end

    always_ff @(posedge clk) begin
        rst_seen_q <= rst_n;
        if (rst_int) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign m_iq_valid = pipe_q.c_v;
    assign m_iq_data  = {pipe_q.c_sin, pipe_q.c_cos};
    assign m_iq_last  = pipe_q.c_last;

    // ---------------- assertions ----------------
    localparam longint AMP = longint'(1) << FRAC_W;

    logic signed [OUT_W-1:0] out_cos, out_sin;
    longint                  mag2;
    assign out_cos = $signed(m_iq_data[OUT_W-1:0]);
    assign out_sin = $signed(m_iq_data[2*OUT_W-1:OUT_W]);
    always_comb mag2 = longint'(out_cos) * longint'(out_cos)
                     + longint'(out_sin) * longint'(out_sin);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        m_iq_valid && !m_iq_ready |=> m_iq_valid && $stable(m_iq_data) && $stable(m_iq_last));

    p_rise_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_iq_valid) |-> $past(s_phase_valid && s_phase_ready));

    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        m_iq_valid |-> (longint'(out_cos) <= AMP) && (longint'(out_cos) >= -AMP)
                    && (longint'(out_sin) <= AMP) && (longint'(out_sin) >= -AMP));

    p_unit_circle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        m_iq_valid |-> (mag2 <= AMP * AMP + 2 * AMP) && (mag2 >= AMP * AMP - 2 * AMP));

    p_reset_idle_r9: assert property (@(posedge clk)
        !rst_n |=> !m_iq_valid && !s_phase_ready);

endmodule

// File: tb/phasor_gen_tb.sv
module phasor_gen_tb;

    localparam real PI = 3.14159265358979323846;
    localparam int  NV = 16;
    // {last, phase}
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 24'h000000}, {1'b0, 24'h400000}, {1'b0, 24'h800000}, {1'b1, 24'hC00000},
        {1'b0, 24'h00FFFF}, {1'b0, 24'h123456}, {1'b0, 24'h2AAAAA}, {1'b1, 24'h555555},
        {1'b0, 24'h7FFFFF}, {1'b0, 24'h9ABCDE}, {1'b1, 24'hBFFFFF}, {1'b0, 24'hE00000},
        {1'b0, 24'hFFFFFF}, {1'b0, 24'h010000}, {1'b1, 24'h3F0000}, {1'b0, 24'h600000}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        s_valid, s_ready, s_last;
    logic [23:0] s_data;
    logic        m_valid, m_ready, m_last;
    logic [31:0] m_data;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int icount = 0;
    int ocount = 0;
    int lat_idx = -1;
    logic [23:0] acc_ph   [64];
    logic        acc_last [64];
    int          acc_cyc  [64];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    phasor_gen u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_phase_valid(s_valid), .s_phase_ready(s_ready),
        .s_phase_data(s_data), .s_phase_last(s_last),
        .m_iq_valid(m_valid), .m_iq_ready(m_ready),
        .m_iq_data(m_data), .m_iq_last(m_last)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int model(input logic [23:0] ph, input bit want_sin);
        real ang;
        real v;
        ang = 2.0 * PI * real'(ph[23:16]) / 256.0;
        v   = 16384.0 * (want_sin ? $sin(ang) : $cos(ang));
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic send(input logic [23:0] ph, input logic lst);
        s_valid = 1'b1;
        s_data  = ph;
        s_last  = lst;
        forever begin
            @(negedge clk);
            if (s_ready) begin
                acc_ph[icount]   = ph;
                acc_last[icount] = lst;
                acc_cyc[icount]  = cyc;
                icount++;
                step();
                break;
            end
            step();
        end
        s_valid = 1'b0;
    endtask

    // Output monitor: compares every transfer against the model.
    always @(negedge clk) begin
        if (rst_n && m_valid && m_ready) begin
            int gc, gs, ec, es, dc, ds, tol;
            logic [23:0] ph;
            string tag;
            ph  = acc_ph[ocount];
            gc  = int'($signed(m_data[15:0]));
            gs  = int'($signed(m_data[31:16]));
            ec  = model(ph, 1'b0);
            es  = model(ph, 1'b1);
            dc  = (gc > ec) ? gc - ec : ec - gc;
            ds  = (gs > es) ? gs - es : es - gs;
            tol = (ph[21:16] == 6'd0) ? 0 : 1;
            tag = (ph[21:16] != 6'd0) ? "R1" : ((ph[15:0] != 16'd0) ? "R4" : "R3");
            chk(dc <= tol, tag, $sformatf("cos of phase %06h", ph), gc, ec);
            chk(ds <= tol, tag, $sformatf("sin of phase %06h", ph), gs, es);
            chk(m_last == acc_last[ocount], "R5", "last flag", m_last, acc_last[ocount]);
            if (ph == 24'h400000)
                chk(m_data == 32'h40000000, "R2", "packed word", m_data, 32'h40000000);
            if (ocount == lat_idx)
                chk(cyc - acc_cyc[ocount] == 3, "R6", "latency", cyc - acc_cyc[ocount], 3);
            ocount++;
        end
    end

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] held;
        rst_n   = 1'b0;
        s_valid = 1'b0;
        s_data  = '0;
        s_last  = 1'b0;
        m_ready = 1'b1;
        repeat (3) step();

        // R9: reset state and the stretched release
        @(negedge clk);
        chk(m_valid == 1'b0, "R9", "valid in reset", m_valid, 0);
        chk(s_ready == 1'b0, "R9", "ready in reset", s_ready, 0);
        step();
        rst_n = 1'b1;
        @(negedge clk);
        chk(s_ready == 1'b0, "R9", "ready one cycle after release", s_ready, 0);
        step();
        @(negedge clk);
        chk(s_ready == 1'b1, "R9", "ready after stretch", s_ready, 1);
        step();

        // Table walk with continuous input (R1..R6)
        lat_idx = icount;
        for (int i = 0; i < NV; i++) send(VEC[i][23:0], VEC[i][24]);
        send(24'h200000, 1'b0);
        send(24'h200000, 1'b1);
        repeat (10) step();
        @(negedge clk);
        chk(ocount == icount - 2, "R7", "outputs after input stops", ocount, icount - 2);
        chk(m_valid == 1'b0, "R7", "no output without input", m_valid, 0);
        step();

        // Back-pressure (R8)
        m_ready = 1'b0;
        send(24'hA00000, 1'b1);
        @(negedge clk);
        chk(m_valid == 1'b1, "R8", "valid under stall", m_valid, 1);
        chk(s_ready == 1'b0, "R8", "ready under stall", s_ready, 0);
        held = m_data;
        for (int k = 0; k < 4; k++) begin
            step();
            @(negedge clk);
            chk(m_data == held, "R8", "data stable under stall", m_data, held);
            chk(s_ready == 1'b0, "R8", "ready held low", s_ready, 0);
        end
        step();
        m_ready = 1'b1;
        send(24'h600000, 1'b0);
        send(24'h300000, 1'b0);
        send(24'hF00000, 1'b1);
        send(24'h000000, 1'b0);
        send(24'h000000, 1'b0);
        repeat (6) step();
        @(negedge clk);
        chk(ocount == icount - 2, "R7", "flush after stall", ocount, icount - 2);
        step();

        // Reset with data in flight (R9)
        send(24'h480000, 1'b1);
        rst_n = 1'b0;
        repeat (2) step();
        @(negedge clk);
        chk(m_valid == 1'b0, "R9", "valid cleared by reset", m_valid, 0);
        chk(s_ready == 1'b0, "R9", "ready low in reset", s_ready, 0);
        step();
        rst_n  = 1'b1;
        ocount = icount;
        repeat (2) step();
        send(24'hC00000, 1'b0);
        send(24'h800000, 1'b1);
        send(24'h400000, 1'b0);
        send(24'h000000, 1'b0);
        send(24'h000000, 1'b0);
        repeat (6) step();
        @(negedge clk);
        chk(ocount == icount - 2, "R7", "outputs after reset", ocount, icount - 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule